// File: doc/BRIEF.md
# Per-Set True LRU Replacement Tracker

This block records, for each set of an 8-way set-associative cache, the complete recency order of its ways. Tag compare and the data arrays sit elsewhere. The cache controller drives this block through two ports:

- **Hit port.** It reports a hit by giving a set number and a way number.
- **Allocate port.** It asks for a way to fill by giving a set number and the valid bit of each way in that set.

The victim way appears on the same cycle as the allocate request. The stored order changes on the next clock edge.

Recency is held as one age per way: age 0 marks the most recently used way, and the highest age marks the least recently used way. An allocation picks its victim as follows:

- If any way in the set is invalid, the lowest-numbered invalid way is chosen.
- If every way is valid, the way with the highest age is chosen.

A single input selects where the new line goes in the order. It can take the most-recent position, or the least-recent position so that streaming data replaces its own earlier fills. The policy that drives this input is outside the block.

Top module: `lru_tracker`

## Requirements
- R1: After synchronous reset, way i of every set holds age i. An allocate with all ways valid therefore picks way 7 in any set.
- R2: A hit sets the hit way's age to 0. Each way whose age was lower than the hit way's old age gains one. All other ages are unchanged.
- R3: A hit on a way that already has age 0 leaves the set's order unchanged.
- R4: If any valid bit on the allocate port is 0, the victim is the lowest-numbered way whose valid bit is 0.
- R5: If all valid bits are 1, the victim is the way holding the highest age (WAYS-1).
- R6: With alloc_insert_lru = 0, a granted allocation moves the victim to age 0, following the same rule as a hit.
- R7: With alloc_insert_lru = 1, a granted allocation moves the victim to age WAYS-1. Each way whose age was above the victim's old age loses one. A following all-valid allocate in that set picks the same way again.
- R8: victim_way is a combinational function of the current stored order and the allocate inputs. The order update takes effect at the next rising clock edge.
- R9: When hit_valid and alloc_valid target the same set in one cycle, alloc_grant is 0. Only the hit updates the order, and the requester must hold its allocate request.
- R10: Sets are independent. A hit and an allocate to different sets in the same cycle are both applied, with alloc_grant = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| hit_valid | input | 1 | Hit report strobe |
| hit_set | input | $clog2(SETS) | Set index of the hit |
| hit_way | input | $clog2(WAYS) | Way that hit |
| alloc_valid | input | 1 | Allocate request strobe |
| alloc_set | input | $clog2(SETS) | Set index to allocate in |
| alloc_way_valid | input | WAYS | Current valid bit of each way in that set |
| alloc_insert_lru | input | 1 | 1: insert at the least-recent position, 0: insert at the most-recent position |
| victim_way | output | $clog2(WAYS) | Way selected for replacement (combinational) |
| alloc_grant | output | 1 | The allocate request is accepted this cycle |

## Verification
The bench aims at the corner cases most likely to expose a wrong design:

- **Hit on the most-recent way.** A wrong shift rule would age the other ways here.
- **Two or more invalid ways.** A wrong scan direction would return the highest-numbered invalid way.
- **Least-recent insertion.** A design that ignored the insertion input would make the following allocation pick a different way.
- **Same-set collision.** A design without the guard would apply both updates and corrupt the order into a non-permutation.

After these directed cases, a long seeded random run with hits and allocations mixed compares every victim and grant against a reference model held in the bench. Any drift in the stored ages shows up there as a wrong victim.

// File: rtl/lru_pkg.sv
package lru_pkg;

    localparam int DEF_WAYS = 8;
    localparam int DEF_SETS = 16;

    typedef enum logic {
        INS_MRU = 1'b0,
        INS_LRU = 1'b1
    } ins_pos_e;

    // Highest age value for a given associativity.
    function automatic int oldest_age(input int ways);
        return ways - 1;
    endfunction

endpackage

// File: rtl/lru_victim_pick.sv
module lru_victim_pick
    import lru_pkg::*;
#(
    parameter int WAYS = DEF_WAYS,
    localparam int AW  = $clog2(WAYS),
    localparam int WW  = $clog2(WAYS)
) (
    input  logic [WAYS-1:0][AW-1:0] ages,
    input  logic [WAYS-1:0]         way_valid,
    output logic [WW-1:0]           victim
);
    logic [WW-1:0] first_invalid;
    logic [WW-1:0] oldest_way;
    logic          any_invalid;

    always_comb begin
        first_invalid = '0;
        any_invalid   = 1'b0;
        // Scan downward so the lowest-numbered invalid way is the last one written.
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (!way_valid[i]) begin
                first_invalid = WW'(i);
                any_invalid   = 1'b1;
            end
        end
    end

    always_comb begin
        oldest_way = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (ages[i] == AW'(oldest_age(WAYS))) oldest_way = WW'(i);
        end
    end

    assign victim = any_invalid ? first_invalid : oldest_way;

endmodule

// File: rtl/lru_order_update.sv
module lru_order_update
    import lru_pkg::*;
#(
    parameter int WAYS = DEF_WAYS,
    localparam int AW  = $clog2(WAYS),
    localparam int WW  = $clog2(WAYS)
) (
    input  logic [WAYS-1:0][AW-1:0] row_in,
    input  logic [WW-1:0]           target,
    input  ins_pos_e                pos,
    output logic [WAYS-1:0][AW-1:0] row_out
);
    logic [AW-1:0] old_age;

    assign old_age = row_in[target];

    always_comb begin
        for (int i = 0; i < WAYS; i++) begin
            row_out[i] = row_in[i];
            if (WW'(i) == target) begin
                row_out[i] = (pos == INS_LRU) ? AW'(oldest_age(WAYS)) : '0;
            end else if (pos == INS_MRU && row_in[i] < old_age) begin
                row_out[i] = row_in[i] + 1'b1;
            end else if (pos == INS_LRU && row_in[i] > old_age) begin
                row_out[i] = row_in[i] - 1'b1;
            end
        end
    end

endmodule

// File: rtl/lru_tracker.sv
module lru_tracker
    import lru_pkg::*;
#(
    parameter int WAYS = DEF_WAYS,
    parameter int SETS = DEF_SETS,
    localparam int AW  = $clog2(WAYS),
    localparam int WW  = $clog2(WAYS),
    localparam int SW  = $clog2(SETS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            hit_valid,
    input  logic [SW-1:0]   hit_set,
    input  logic [WW-1:0]   hit_way,
    input  logic            alloc_valid,
    input  logic [SW-1:0]   alloc_set,
    input  logic [WAYS-1:0] alloc_way_valid,
    input  logic            alloc_insert_lru,
    output logic [WW-1:0]   victim_way,
    output logic            alloc_grant
);
    logic [WAYS-1:0][AW-1:0] age_q [SETS];
    logic [WAYS-1:0][AW-1:0] hit_row_new;
    logic [WAYS-1:0][AW-1:0] alloc_row_new;
    ins_pos_e                alloc_pos;

    assign alloc_pos   = alloc_insert_lru ? INS_LRU : INS_MRU;
    assign alloc_grant = alloc_valid && !(hit_valid && hit_set == alloc_set);

    lru_victim_pick #(.WAYS(WAYS)) u_pick (
        .ages      (age_q[alloc_set]),
        .way_valid (alloc_way_valid),
        .victim    (victim_way)
    );

    lru_order_update #(.WAYS(WAYS)) u_hit_upd (
        .row_in  (age_q[hit_set]),
        .target  (hit_way),
        .pos     (INS_MRU),
        .row_out (hit_row_new)
    );

    lru_order_update #(.WAYS(WAYS)) u_alloc_upd (
        .row_in  (age_q[alloc_set]),
        .target  (victim_way),
        .pos     (alloc_pos),
        .row_out (alloc_row_new)
    );

    generate
        for (genvar s = 0; s < SETS; s++) begin : g_set
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int w = 0; w < WAYS; w++) age_q[s][w] <= AW'(w);
                end else if (hit_valid && hit_set == SW'(s)) begin
                    age_q[s] <= hit_row_new;
                end else if (alloc_grant && alloc_set == SW'(s)) begin
                    age_q[s] <= alloc_row_new;
                end
            end
        end
    endgenerate

    // R2: the stored age of a hit way is 0 after the edge
    a_r2_hit_to_mru: assert property (@(posedge clk) disable iff (rst)
        hit_valid |=> age_q[$past(hit_set)][$past(hit_way)] == '0);

    // R4: with an invalid way present, the victim is never a valid way
    a_r4_invalid_first: assert property (@(posedge clk) disable iff (rst)
        (alloc_valid && !(&alloc_way_valid)) |-> !alloc_way_valid[victim_way]);

    // R5: with all ways valid, the victim holds the oldest age
    a_r5_lru_victim: assert property (@(posedge clk) disable iff (rst)
        (alloc_valid && (&alloc_way_valid)) |-> age_q[alloc_set][victim_way] == AW'(WAYS - 1));

    // R7: least-recent insertion leaves the victim at the oldest age
    a_r7_lru_insert: assert property (@(posedge clk) disable iff (rst)
        (alloc_grant && alloc_insert_lru) |=>
            age_q[$past(alloc_set)][$past(victim_way)] == AW'(WAYS - 1));

    // R6: most-recent insertion leaves the victim at age 0
    a_r6_mru_insert: assert property (@(posedge clk) disable iff (rst)
        (alloc_grant && !alloc_insert_lru) |=> age_q[$past(alloc_set)][$past(victim_way)] == '0);

    // R9: a same-set hit blocks the allocation from touching the order
    a_r9_collision_block: assert property (@(posedge clk) disable iff (rst)
        (hit_valid && alloc_valid && hit_set == alloc_set) |-> !alloc_grant);

endmodule

// File: tb/lru_tracker_test.sv
module lru_tracker_test;
    localparam int WAYS = 8;
    localparam int SETS = 16;
    localparam int WW   = $clog2(WAYS);
    localparam int SW   = $clog2(SETS);

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            hit_valid = 1'b0;
    logic [SW-1:0]   hit_set = '0;
    logic [WW-1:0]   hit_way = '0;
    logic            alloc_valid = 1'b0;
    logic [SW-1:0]   alloc_set = '0;
    logic [WAYS-1:0] alloc_way_valid = '1;
    logic            alloc_insert_lru = 1'b0;
    logic [WW-1:0]   victim_way;
    logic            alloc_grant;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;
    int model [SETS][WAYS];

    always #4 clk = ~clk;   // 125 MHz

    lru_tracker #(.WAYS(WAYS), .SETS(SETS)) uut (
        .clk(clk), .rst(rst),
        .hit_valid(hit_valid), .hit_set(hit_set), .hit_way(hit_way),
        .alloc_valid(alloc_valid), .alloc_set(alloc_set),
        .alloc_way_valid(alloc_way_valid), .alloc_insert_lru(alloc_insert_lru),
        .victim_way(victim_way), .alloc_grant(alloc_grant)
    );

    function automatic int model_victim(int s, logic [WAYS-1:0] v);
        for (int i = 0; i < WAYS; i++) if (!v[i]) return i;
        for (int i = 0; i < WAYS; i++) if (model[s][i] == WAYS - 1) return i;
        return -1;
    endfunction

    function automatic void model_touch(int s, int w, bit to_lru);
        int old = model[s][w];
        for (int j = 0; j < WAYS; j++) begin
            if (j == w) continue;
            if (!to_lru && model[s][j] < old) model[s][j]++;
            if (to_lru && model[s][j] > old) model[s][j]--;
        end
        model[s][w] = to_lru ? WAYS - 1 : 0;
    endfunction

    task automatic check(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    endtask

    // Drive one cycle on the falling edge, check the combinational outputs, advance the model.
    task automatic step(bit hv, int hs, int hw, bit av, int as,
                        logic [WAYS-1:0] vv, bit ins, string tag);
        int exp_v;
        bit exp_g;
        @(negedge clk);
        hit_valid = hv; hit_set = SW'(hs); hit_way = WW'(hw);
        alloc_valid = av; alloc_set = SW'(as); alloc_way_valid = vv;
        alloc_insert_lru = ins;
        #1;
        exp_g = av && !(hv && hs == as);
        if (av) begin
            exp_v = model_victim(as, vv);
            check({tag, " victim"}, int'(victim_way), exp_v);
            check({tag, " grant"}, int'(alloc_grant), int'(exp_g));
        end
        if (hv) model_touch(hs, hw, 1'b0);
        if (exp_g) model_touch(as, exp_v, ins);
        @(posedge clk);
    endtask

    initial begin
        #(8 * 100000);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd12345));
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) model[s][w] = w;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset order, way 7 oldest in the first and last set
        step(0, 0, 0, 1, 0, '1, 0, "R1 set0");
        step(0, 0, 0, 1, SETS - 1, '1, 0, "R1 lastset");
        // R2: hit on way 7 makes way 6 the oldest
        step(1, 1, 7, 0, 0, '1, 0, "R2 hit");
        step(0, 0, 0, 1, 1, '1, 0, "R2 after hit");
        step(1, 1, 3, 0, 0, '1, 0, "R2 hit mid");
        step(0, 0, 0, 1, 1, '1, 1, "R2 after mid");
        // R3: hit on the newest way changes nothing
        step(1, 2, 0, 0, 0, '1, 0, "R3 hit mru");
        step(0, 0, 0, 1, 2, '1, 1, "R3 after");
        // R4: several invalid ways, lowest wins
        step(0, 0, 0, 1, 3, 8'b1111_0101, 0, "R4 lowest invalid");
        step(0, 0, 0, 1, 3, 8'b0111_1111, 0, "R4 top invalid");
        // R5/R6: all valid picks oldest, normal insertion to newest
        step(0, 0, 0, 1, 8, '1, 0, "R5 R6 first");
        step(0, 0, 0, 1, 8, '1, 0, "R5 R6 second");
        // R7: insert at oldest position, next allocation picks same way
        step(0, 0, 0, 1, 4, 8'b1111_1011, 1, "R7 invalid to lru");
        step(0, 0, 0, 1, 4, '1, 1, "R7 repeat");
        step(0, 0, 0, 1, 4, '1, 0, "R7 again");
        // R9: same-set collision, hit wins
        step(1, 5, 7, 1, 5, '1, 0, "R9 collide");
        step(0, 0, 0, 1, 5, '1, 0, "R9 after");
        // R10: hit and allocate in different sets together
        step(1, 6, 7, 1, 7, '1, 0, "R10 both");
        step(0, 0, 0, 1, 6, '1, 0, "R10 hit set");
        step(0, 0, 0, 1, 7, '1, 0, "R10 alloc set");
        // R8: victim follows the order on the cycle right after the update
        step(0, 0, 0, 1, 9, '1, 1, "R8 upd");
        step(0, 0, 0, 1, 9, '1, 0, "R8 next");

        // Random mix
        for (int k = 0; k < 3000; k++) begin
            logic [WAYS-1:0] vv;
            vv = ($urandom_range(0, 2) == 0) ? WAYS'($urandom) : '1;
            step($urandom_range(0, 1), $urandom_range(0, SETS - 1), $urandom_range(0, WAYS - 1),
                 $urandom_range(0, 1), $urandom_range(0, SETS - 1), vv,
                 $urandom_range(0, 1), "R2 R4 R5 R6 R7 R9 R10 random");
        end
        finish_run();
    end
endmodule